// File: doc/BRIEF.md
# Wakeup Pin Interrupt Controller

This block stays powered while the rest of the chip sleeps. It watches a configurable set of wakeup pins and raises a single wake output as soon as one enabled pin sees the event it was set up to detect. Each pin can watch for a low-to-high transition, a high-to-low transition, either transition, or a steady level. When one of these events happens, a sticky status bit for that pin is set.

Software reaches the block through a small 32-bit word-addressed register port. Two leading words are plain storage for timer values. After them come five groups of per-pin words, one bit per pin and 32 pins per word. Before sleep, software clears the status words, and after waking it reads them to find out which pin woke the chip. Every pin is first brought into the clock domain by a two-flop synchroniser. A small two-state machine (states `WK_IDLE` and `WK_ACTIVE`) registers the wake output. It moves from `WK_IDLE` to `WK_ACTIVE` when any enabled pin has a pending status bit. It moves back when none remains.

Top module: `wake_pin_ctrl`

## Requirements
- R1: After reset, both timer words and every enable, edge, polarity and status word read zero, and `wake_o` is low.
- R2: With N = ceil(PIN_COUNT/32), word addresses 0 and 1 are read/write timer words. Word i of group g sits at word address g*N + i + 2. The groups are enable (g=0), falling edge (g=1), rising edge (g=2), polarity (g=3) and status (g=4). Pin p is bit p mod 32 of word p/32 in every group.
- R3: A pin whose rising-edge bit is set records an event on a low-to-high transition and none on a high-to-low transition.
- R4: A pin whose falling-edge bit is set records an event on a high-to-low transition and none on a low-to-high transition.
- R5: A pin with both edge bits set records an event on either transition.
- R6: A pin with both edge bits clear is level-triggered. It records an event while the synchronised pin equals its polarity bit: 1 means active-high, 0 means active-low.
- R7: Events on pins whose enable bit is clear never set their status bit.
- R8: A status bit stays set until software writes a 0 to that bit. Writing a 1 leaves it unchanged. A hardware event in the same cycle as a clearing write wins.
- R9: `wake_o` is the registered OR, over all pins, of status AND enable. It falls when the last enabled pending bit is cleared or its enable is cleared.
- R10: Reads of addresses above the last status word return zero, and writes to them change nothing. Bits for pins at or above PIN_COUNT are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | PIN_COUNT | Asynchronous wakeup pins |
| addr_i | input | ADDR_W | Word address of the register port |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| wake_o | output | 1 | Wake request, registered |

## Verification
The assertions check on every cycle that:
- edge-mode pins raise no event while their synchronised level is steady;
- status bits never fall except under a clearing write, and never rise without an enabled event;
- an event always sets its status bit on the next edge;
- writes outside the map leave the configuration untouched;
- the wake state follows pending status one cycle later.

Only the bench scenarios can show the decoded register layout, the correct event for each combination of edge and polarity bits, the reset contents, the zero padding, and the interplay of enable and clearing writes with the wake output.

// File: rtl/wpic_pkg.sv
package wpic_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_GROUPS  = 5;
    localparam int TIMER_WORDS = 2;

    typedef enum logic [2:0] {
        GRP_ENABLE = 3'd0,
        GRP_FALL   = 3'd1,
        GRP_RISE   = 3'd2,
        GRP_POL    = 3'd3,
        GRP_STATUS = 3'd4
    } grp_e;

    typedef enum logic {
        WK_IDLE   = 1'b0,
        WK_ACTIVE = 1'b1
    } wake_state_e;

    function automatic int words_for(input int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/wpic_sync.sv
module wpic_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/wpic_detect.sv
module wpic_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] rise_sel_i,
    input  logic [WIDTH-1:0] fall_sel_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] event_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rose;
    logic [WIDTH-1:0] fell;
    logic [WIDTH-1:0] edge_mode;
    logic [WIDTH-1:0] level_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= lvl_i;
    end

    always_comb begin
        rose      = lvl_i & ~prev_q;
        fell      = ~lvl_i & prev_q;
        edge_mode = rise_sel_i | fall_sel_i;
        level_hit = ~(lvl_i ^ pol_i);
        event_o   = en_i & ((edge_mode & ((rise_sel_i & rose) | (fall_sel_i & fell)))
                          | (~edge_mode & level_hit));
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        assert_edge_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((rise_sel_i[b] || fall_sel_i[b]) && (lvl_i[b] == prev_q[b])) |-> !event_o[b]);
    end
endmodule

// File: rtl/wpic_regs.sv
module wpic_regs
    import wpic_pkg::*;
#(
    parameter int PIN_COUNT = 40,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    input  logic [PIN_COUNT-1:0] event_i,
    output logic [PIN_COUNT-1:0] en_o,
    output logic [PIN_COUNT-1:0] rise_o,
    output logic [PIN_COUNT-1:0] fall_o,
    output logic [PIN_COUNT-1:0] pol_o,
    output logic [PIN_COUNT-1:0] stat_o
);
    localparam int N       = words_for(PIN_COUNT);
    localparam int BITS    = N * WORD_W;
    localparam int CFG_GRP = NUM_GROUPS - 1;
    localparam int LIMIT   = TIMER_WORDS + NUM_GROUPS * N;

    function automatic logic [BITS-1:0] valid_mask();
        logic [BITS-1:0] m;
        for (int b = 0; b < BITS; b++) m[b] = (b < PIN_COUNT);
        return m;
    endfunction
    localparam logic [BITS-1:0] VALID = valid_mask();

    logic [WORD_W-1:0] timer_q [TIMER_WORDS];
    logic [BITS-1:0]   cfg_q [CFG_GRP];
    logic [BITS-1:0]   stat_q;
    logic [BITS-1:0]   ev_pad;
    logic [BITS-1:0]   clr_bit;
    logic [NUM_GROUPS-1:0][N-1:0] hit;
    logic [TIMER_WORDS-1:0]       thit;
    logic                          out_of_range;

    always_comb begin
        for (int t = 0; t < TIMER_WORDS; t++)
            thit[t] = (int'(addr_i) == t);
        for (int g = 0; g < NUM_GROUPS; g++)
            for (int i = 0; i < N; i++)
                hit[g][i] = (int'(addr_i) == TIMER_WORDS + g * N + i);
        out_of_range = (int'(addr_i) >= LIMIT);
        ev_pad = '0;
        ev_pad[PIN_COUNT-1:0] = event_i;
        for (int b = 0; b < BITS; b++)
            clr_bit[b] = we_i && hit[int'(GRP_STATUS)][b / WORD_W] && !wdata_i[b % WORD_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int t = 0; t < TIMER_WORDS; t++) timer_q[t] <= '0;
            for (int g = 0; g < CFG_GRP; g++)     cfg_q[g]   <= '0;
            stat_q <= '0;
        end else begin
            for (int t = 0; t < TIMER_WORDS; t++)
                if (we_i && thit[t]) timer_q[t] <= wdata_i;
            for (int g = 0; g < CFG_GRP; g++)
                for (int i = 0; i < N; i++)
                    if (we_i && hit[g][i])
                        cfg_q[g][i*WORD_W +: WORD_W] <= wdata_i & VALID[i*WORD_W +: WORD_W];
            stat_q <= (ev_pad | (stat_q & ~clr_bit)) & VALID;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int t = 0; t < TIMER_WORDS; t++)
            if (thit[t]) rdata_o = timer_q[t];
        for (int i = 0; i < N; i++) begin
            for (int g = 0; g < CFG_GRP; g++)
                if (hit[g][i]) rdata_o = cfg_q[g][i*WORD_W +: WORD_W];
            if (hit[int'(GRP_STATUS)][i]) rdata_o = stat_q[i*WORD_W +: WORD_W];
        end
    end

    assign en_o   = cfg_q[int'(GRP_ENABLE)][PIN_COUNT-1:0];
    assign fall_o = cfg_q[int'(GRP_FALL)][PIN_COUNT-1:0];
    assign rise_o = cfg_q[int'(GRP_RISE)][PIN_COUNT-1:0];
    assign pol_o  = cfg_q[int'(GRP_POL)][PIN_COUNT-1:0];
    assign stat_o = stat_q[PIN_COUNT-1:0];

    for (genvar b = 0; b < PIN_COUNT; b++) begin : g_stat_chk
        assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_q[b] && !clr_bit[b]) |=> stat_q[b]);
        assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ev_pad[b] |=> stat_q[b]);
        assert_no_spurious_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(stat_q[b]) |-> $past(ev_pad[b]));
    end
    for (genvar g = 0; g < CFG_GRP; g++) begin : g_cfg_chk
        assert_outside_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && out_of_range) |=> $stable(cfg_q[g]));
    end
endmodule

// File: rtl/wake_pin_ctrl.sv
module wake_pin_ctrl
    import wpic_pkg::*;
#(
    parameter int PIN_COUNT = 40,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [PIN_COUNT-1:0] pins_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic                 wake_o
);
    logic [PIN_COUNT-1:0] lvl;
    logic [PIN_COUNT-1:0] en;
    logic [PIN_COUNT-1:0] rise_sel;
    logic [PIN_COUNT-1:0] fall_sel;
    logic [PIN_COUNT-1:0] pol;
    logic [PIN_COUNT-1:0] stat;
    logic [PIN_COUNT-1:0] events;
    logic                 pending;
    wake_state_e          state_q, state_d;

    wpic_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pins_i),
        .sync_o (lvl)
    );

    wpic_detect #(.WIDTH(PIN_COUNT)) u_detect (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (lvl),
        .en_i      (en),
        .rise_sel_i(rise_sel),
        .fall_sel_i(fall_sel),
        .pol_i     (pol),
        .event_o   (events)
    );

    wpic_regs #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .addr_i (addr_i),
        .we_i   (we_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .event_i(events),
        .en_o   (en),
        .rise_o (rise_sel),
        .fall_o (fall_sel),
        .pol_o  (pol),
        .stat_o (stat)
    );

    assign pending = |(stat & en);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:   if (pending)  state_d = WK_ACTIVE;
            WK_ACTIVE: if (!pending) state_d = WK_IDLE;
            default:   state_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WK_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        wake_o = (state_q == WK_ACTIVE);
    end

    assert_wake_rises_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending |=> wake_o);
    assert_wake_falls_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pending |=> !wake_o);
endmodule

// File: tb/wake_pin_ctrl_tb_top.sv
module wake_pin_ctrl_tb_top;
    localparam int PINS = 40;
    localparam int AW   = 8;
    // word map for 40 pins (N=2): en 2/3, fall 4/5, rise 6/7, pol 8/9, status 10/11
    localparam int A_EN1 = 3, A_FALL1 = 5, A_RISE1 = 7, A_POL1 = 9, A_ST0 = 10, A_ST1 = 11;
    localparam int TPIN = 1;   // pin 33 = bit 1 of word 1

    typedef struct packed {
        logic       rise;
        logic       fall;
        logic       pol;
        logic       start;
        logic       stop;
        logic       expect_hit;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3}, // R3 rise seen
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 fall ignored
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd4}, // R4 fall seen
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4}, // R4 rise ignored
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5}, // R5 rise
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd5}, // R5 fall
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd6}, // R6 active high hit
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6}, // R6 active high idle
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd6}, // R6 active low hit
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6}  // R6 active low idle
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pins = '0;
    logic [AW-1:0]   addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            wake;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    wake_pin_ctrl #(.PIN_COUNT(PINS), .ADDR_W(AW)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .pins_i (pins),
        .addr_i (addr),
        .we_i   (we),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .wake_o (wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        bit          all_zero;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: all words zero after reset, wake low
        all_zero = 1'b1;
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            if (v !== 32'h0) all_zero = 1'b0;
        end
        check("R1 reset words", {31'h0, all_zero}, 32'h1);
        check("R1 reset wake", {31'h0, wake}, 32'h0);

        // vector table: edge and level modes on pin 33
        for (int k = 0; k < 10; k++) begin
            wr(A_EN1, 32'h0);
            wr(A_ST1, 32'h0);
            wr(A_RISE1, {31'h0, VECS[k].rise} << TPIN);
            wr(A_FALL1, {31'h0, VECS[k].fall} << TPIN);
            wr(A_POL1,  {31'h0, VECS[k].pol}  << TPIN);
            pins[32+TPIN] = VECS[k].start;
            idle(5);
            wr(A_EN1, 32'h1 << TPIN);
            idle(5);
            wr(A_ST1, 32'h0);
            idle(2);
            pins[32+TPIN] = VECS[k].stop;
            idle(6);
            rd(A_ST1, v);
            check($sformatf("R%0d vector %0d status", VECS[k].req, k), v,
                  {31'h0, VECS[k].expect_hit} << TPIN);
            check($sformatf("R%0d vector %0d wake (R9)", VECS[k].req, k),
                  {31'h0, wake}, {31'h0, VECS[k].expect_hit});
        end
        wr(A_EN1, 32'h0); wr(A_ST1, 32'h0);
        wr(A_RISE1, 32'h0); wr(A_FALL1, 32'h0); wr(A_POL1, 32'h0);
        pins = '0;
        idle(4);

        // R2: timer words and group layout
        wr(0, 32'hA5A5_1234);
        wr(1, 32'h0F0F_F0F0);
        rd(0, v); check("R2 timer0", v, 32'hA5A5_1234);
        rd(1, v); check("R2 timer1", v, 32'h0F0F_F0F0);
        wr(4, 32'h1234_5678);
        rd(4, v); check("R2 fall word0", v, 32'h1234_5678);
        rd(2, v); check("R2 enable word0 untouched", v, 32'h0);
        wr(4, 32'h0);

        // R10: padding bits and out-of-range access
        wr(A_POL1, 32'hFFFF_FFFF);
        rd(A_POL1, v); check("R10 pad bits zero", v, 32'h0000_00FF);
        wr(A_POL1, 32'h0);
        wr(12, 32'hFFFF_FFFF);
        wr(200, 32'hFFFF_FFFF);
        rd(12, v); check("R10 read beyond map", v, 32'h0);
        all_zero = 1'b1;
        for (int a = 2; a < 12; a++) begin
            rd(a, v);
            if (v !== 32'h0) all_zero = 1'b0;
        end
        check("R10 ignored writes", {31'h0, all_zero}, 32'h1);

        // R7: disabled pin does not record (pin 5, rise mode)
        wr(6, 32'h20);
        pins[5] = 1'b1;
        idle(6);
        rd(A_ST0, v); check("R7 disabled pin no status", v, 32'h0);
        check("R7 wake low", {31'h0, wake}, 32'h0);
        pins[5] = 1'b0;
        idle(5);
        wr(2, 32'h20);
        idle(4);
        rd(A_ST0, v); check("R7 enable alone no event", v, 32'h0);
        pins[5] = 1'b1;
        idle(6);
        rd(A_ST0, v); check("R3 enabled rise", v, 32'h20);

        // R8: writing one keeps status, writing zero clears it
        wr(A_ST0, 32'hFFFF_FFFF);
        rd(A_ST0, v); check("R8 write one keeps", v, 32'h20);
        check("R9 wake high", {31'h0, wake}, 32'h1);

        // R9: disable drops wake while status stays
        wr(2, 32'h0);
        idle(2);
        check("R9 wake low after disable", {31'h0, wake}, 32'h0);
        rd(A_ST0, v); check("R9 status kept", v, 32'h20);
        wr(2, 32'h20);
        idle(2);
        check("R9 wake back", {31'h0, wake}, 32'h1);
        wr(A_ST0, 32'hFFFF_FFDF);
        rd(A_ST0, v); check("R8 write zero clears", v, 32'h0);
        idle(2);
        check("R9 wake low after clear", {31'h0, wake}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule